// File: doc/BRIEF.md
# Polynomial-Counter Tone Channel

This block produces the amplitude of one sound channel. A slow base enable (nominally about 30 kHz, one clock cycle wide per base period) is first divided by a programmable 5-bit period value. Each divided step advances a waveform generator whose behaviour is chosen by a 4-bit shape code. The available shapes include a constant level, three maximal-length linear-feedback shift registers (4, 5 and 9 bits), fixed divide-by-2, 6, 31 and 93 paths, and chained combinations where one source gates the next. The single waveform bit then selects between silence and a 4-bit volume.

Software writes the period, shape and volume through three independent write strobes. The registers take their new values on the clock edge of the strobe. Changing the shape or period never clears the shift registers, the toggle or the divide counter, so a running sound can be retuned without a click back to a fixed phase.

The waveform source is modelled as a set of decoded modes. They are HIGH, P4, P9, P5, DIV2, DIV6, DIV31, DIV93, D15P4, P5P4, P5D2 and P5D6. Each divided step performs the transitions that belong to the active mode, as listed in the requirements.

Top module: `tone_channel`

## Requirements
- R1: With period value f, a divided step occurs on every (f+1)-th base enable: f = 0 steps on every enable and f = 31 steps on every 32nd. A step is an internal event, seen only through its effect on the waveform. The divider is a down-counter. When it is at zero, a base enable produces a step and reloads the counter with f. Otherwise a base enable decrements the counter.
- R2: A new period value is used only at the next reload. The countdown already in progress finishes with the old value, and the write leaves the waveform state untouched.
- R3: Shape codes 0000 and 1011 (mode HIGH) hold the waveform bit at 1.
- R4: Three linear-feedback shift registers are used, each shifting left with the feedback bit entering at bit 0:
  - the 4-bit register takes feedback s[3]^s[2];
  - the 5-bit register takes s[4]^s[2];
  - the 9-bit register takes s[8]^s[4].
  
  All three reset to all ones. Code 0001 (P4) advances the 4-bit register on every step, 1001 (P5) the 5-bit register and 1000 (P9) the 9-bit register. The waveform bit is the most significant bit of the selected register.
- R5: Codes 0100 and 0101 (DIV2) invert a toggle bit, reset to 0, on every step. The waveform bit is that toggle.
- R6: Each fixed divider uses a shared counter, reset to 0, that runs 0..N-1 and wraps. The waveform bit is 1 while the count is below ceil(N/2).
  - Codes 1100 and 1101 (DIV6) use N = 6.
  - Codes 0110 and 1010 (DIV31) use N = 31.
  - Code 1110 (DIV93) uses N = 93.
- R7: Code 0010 (D15P4) runs the shared counter modulo 15. The 4-bit register advances only on the step where the counter wraps from 14 to 0, and the waveform bit is the 4-bit register's MSB.
- R8: In codes 0011 (P5P4), 0111 (P5D2) and 1111 (P5D6) the 5-bit register advances on every step. The chained element moves only on steps where the 5-bit MSB, before that step's shift, is 1:
  - in P5P4 the 4-bit register advances, and the waveform bit is its MSB;
  - in P5D2 the toggle inverts, and the waveform bit is the toggle;
  - in P5D6 the counter advances modulo 6, and the waveform bit is 1 while the count is below 3.
- R9: The output amplitude equals the volume register when the waveform bit is 1 and 0 otherwise. A volume of 0000 is silent, and a volume write shows on the output in the next cycle without any step.
- R10: After reset the period, shape and volume registers are 0, the divider counter is 0 and the output is 0.
- R11: Changing the shape code keeps all generator state. If the shared counter is at or beyond the new mode's limit N-1, the next counting step wraps it to 0. This applies to DIV6, DIV31, DIV93 and D15P4, and to P5D6 when it counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Base tone-clock enable, one cycle wide |
| freq_we | input | 1 | Period register write strobe |
| freq_data | input | FREQ_W (5) | Period value f (divide by f+1) |
| ctrl_we | input | 1 | Shape register write strobe |
| ctrl_data | input | 4 | Shape code |
| vol_we | input | 1 | Volume register write strobe |
| vol_data | input | VOL_W (4) | Volume value |
| amp_o | output | VOL_W (4) | Output amplitude |

## Verification
The bench builds the channel with its default widths, a 5-bit period and a 4-bit volume. These widths let it sweep period values from 0 to 31 and volumes from silent to full scale. With period 0, a run of up to 255 base enables reaches past a complete DIV93 cycle, several D15P4 advances and many 5-bit register wraps. A reference model in the bench tracks every shape code step by step. Directed cases cover a mid-count period change, a mode switch with the counter past its new limit, and the first five steps of the 5-bit register from all ones.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int unsigned SHAPE_W = 4;
    localparam int unsigned CNT_W   = 7;

    localparam logic [CNT_W-1:0] N_DIV6  = 7'd6;
    localparam logic [CNT_W-1:0] N_DIV15 = 7'd15;
    localparam logic [CNT_W-1:0] N_DIV31 = 7'd31;
    localparam logic [CNT_W-1:0] N_DIV93 = 7'd93;

    typedef enum logic [3:0] {
        WV_HIGH,
        WV_P4,
        WV_P9,
        WV_P5,
        WV_DIV2,
        WV_DIV6,
        WV_DIV31,
        WV_DIV93,
        WV_D15P4,
        WV_P5P4,
        WV_P5D2,
        WV_P5D6
    } wave_sel_e;

    function automatic wave_sel_e decode_shape(input logic [SHAPE_W-1:0] code);
        wave_sel_e sel;
        unique case (code)
            4'b0000: sel = WV_HIGH;
            4'b0001: sel = WV_P4;
            4'b0010: sel = WV_D15P4;
            4'b0011: sel = WV_P5P4;
            4'b0100: sel = WV_DIV2;
            4'b0101: sel = WV_DIV2;
            4'b0110: sel = WV_DIV31;
            4'b0111: sel = WV_P5D2;
            4'b1000: sel = WV_P9;
            4'b1001: sel = WV_P5;
            4'b1010: sel = WV_DIV31;
            4'b1011: sel = WV_HIGH;
            4'b1100: sel = WV_DIV6;
            4'b1101: sel = WV_DIV6;
            4'b1110: sel = WV_DIV93;
            4'b1111: sel = WV_P5D6;
            default: sel = WV_HIGH;
        endcase
        return sel;
    endfunction

    // Threshold below which a divider output is high: ceil(N/2)
    function automatic logic [CNT_W-1:0] high_limit(input logic [CNT_W-1:0] n);
        return CNT_W'((n + CNT_W'(1)) >> 1);
    endfunction

endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler #(
    parameter int unsigned FREQ_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [FREQ_W-1:0] period_i,
    output logic              step_o
);

    logic [FREQ_W-1:0] cnt_q;
    logic [FREQ_W-1:0] cnt_d;

    always_comb begin
        step_o = tick_en && (cnt_q == '0);
        cnt_d  = cnt_q;
        if (tick_en) begin
            if (cnt_q == '0) cnt_d = period_i;
            else             cnt_d = cnt_q - FREQ_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

endmodule

// File: rtl/tone_lfsr.sv
module tone_lfsr #(
    parameter int unsigned WIDTH = 5,
    parameter int unsigned TAP   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic msb_o
);

    logic [WIDTH-1:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= '1;
        else if (adv_i) state_q <= {state_q[WIDTH-2:0], state_q[WIDTH-1] ^ state_q[TAP]};
    end

    assign msb_o = state_q[WIDTH-1];

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/tone_wavegen.sv
module tone_wavegen
    import tone_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step_i,
    input  wave_sel_e sel_i,
    output logic      wave_o
);

    localparam int unsigned NUM_POLY = 3;
    localparam int unsigned POLY_W   [NUM_POLY] = '{4, 5, 9};
    localparam int unsigned POLY_TAP [NUM_POLY] = '{2, 2, 4};
    localparam int unsigned IX4 = 0;
    localparam int unsigned IX5 = 1;
    localparam int unsigned IX9 = 2;

    logic [NUM_POLY-1:0] poly_adv;
    logic [NUM_POLY-1:0] poly_msb;
    logic                tog_q;
    logic                tog_adv;
    logic [CNT_W-1:0]    cnt_q;
    logic                cnt_adv;
    logic [CNT_W-1:0]    cnt_mod;
    logic                cnt_wrap;

    for (genvar gi = 0; gi < NUM_POLY; gi++) begin : g_poly
        tone_lfsr #(
            .WIDTH(POLY_W[gi]),
            .TAP  (POLY_TAP[gi])
        ) u_lfsr (
            .clk  (clk),
            .rst_n(rst_n),
            .adv_i(poly_adv[gi]),
            .msb_o(poly_msb[gi])
        );
    end

    assign cnt_wrap = (cnt_q >= CNT_W'(cnt_mod - CNT_W'(1)));

    // Transition decode: which state elements move on this step
    always_comb begin
        poly_adv = '0;
        tog_adv  = 1'b0;
        cnt_adv  = 1'b0;
        cnt_mod  = N_DIV6;
        unique case (sel_i)
            WV_HIGH:  ;
            WV_P4:    poly_adv[IX4] = step_i;
            WV_P9:    poly_adv[IX9] = step_i;
            WV_P5:    poly_adv[IX5] = step_i;
            WV_DIV2:  tog_adv = step_i;
            WV_DIV6:  begin cnt_adv = step_i; cnt_mod = N_DIV6;  end
            WV_DIV31: begin cnt_adv = step_i; cnt_mod = N_DIV31; end
            WV_DIV93: begin cnt_adv = step_i; cnt_mod = N_DIV93; end
            WV_D15P4: begin
                cnt_adv       = step_i;
                cnt_mod       = N_DIV15;
                poly_adv[IX4] = step_i && cnt_wrap;
            end
            WV_P5P4: begin
                poly_adv[IX5] = step_i;
                poly_adv[IX4] = step_i && poly_msb[IX5];
            end
            WV_P5D2: begin
                poly_adv[IX5] = step_i;
                tog_adv       = step_i && poly_msb[IX5];
            end
            WV_P5D6: begin
                poly_adv[IX5] = step_i;
                cnt_adv       = step_i && poly_msb[IX5];
                cnt_mod       = N_DIV6;
            end
            default: ;
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (tog_adv) tog_q <= ~tog_q;
            if (cnt_adv) cnt_q <= cnt_wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Waveform output selection
    always_comb begin
        unique case (sel_i)
            WV_HIGH:  wave_o = 1'b1;
            WV_P4:    wave_o = poly_msb[IX4];
            WV_P9:    wave_o = poly_msb[IX9];
            WV_P5:    wave_o = poly_msb[IX5];
            WV_DIV2:  wave_o = tog_q;
            WV_DIV6:  wave_o = cnt_q < high_limit(N_DIV6);
            WV_DIV31: wave_o = cnt_q < high_limit(N_DIV31);
            WV_DIV93: wave_o = cnt_q < high_limit(N_DIV93);
            WV_D15P4: wave_o = poly_msb[IX4];
            WV_P5P4:  wave_o = poly_msb[IX4];
            WV_P5D2:  wave_o = tog_q;
            WV_P5D6:  wave_o = cnt_q < high_limit(N_DIV6);
            default:  wave_o = 1'b1;
        endcase
    end

    // R5
    div2_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == WV_DIV2 && step_i) |=> (wave_o != $past(wave_o)));

    // R11
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < N_DIV93);

    // R3
    high_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == WV_HIGH) |-> wave_o);

endmodule

// File: rtl/tone_channel.sv
module tone_channel
    import tone_pkg::*;
#(
    parameter int unsigned FREQ_W = 5,
    parameter int unsigned VOL_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               freq_we,
    input  logic [FREQ_W-1:0]  freq_data,
    input  logic               ctrl_we,
    input  logic [SHAPE_W-1:0] ctrl_data,
    input  logic               vol_we,
    input  logic [VOL_W-1:0]   vol_data,
    output logic [VOL_W-1:0]   amp_o
);

    logic [FREQ_W-1:0]  freq_q;
    logic [SHAPE_W-1:0] shape_q;
    logic [VOL_W-1:0]   vol_q;
    logic               step;
    logic               wave;
    wave_sel_e          sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q  <= '0;
            shape_q <= '0;
            vol_q   <= '0;
        end else begin
            if (freq_we) freq_q  <= freq_data;
            if (ctrl_we) shape_q <= ctrl_data;
            if (vol_we)  vol_q   <= vol_data;
        end
    end

    assign sel = decode_shape(shape_q);

    tone_prescaler #(.FREQ_W(FREQ_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .period_i(freq_q),
        .step_o  (step)
    );

    tone_wavegen u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(step),
        .sel_i (sel),
        .wave_o(wave)
    );

    assign amp_o = wave ? vol_q : '0;

    // R9
    amp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vol_we && !ctrl_we && !step) |=> $stable(amp_o));

endmodule

// File: tb/tone_channel_tb_top.sv
`timescale 1ns/1ps
module tone_channel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       freq_we = 1'b0;
    logic [4:0] freq_data = '0;
    logic       ctrl_we = 1'b0;
    logic [3:0] ctrl_data = '0;
    logic       vol_we = 1'b0;
    logic [3:0] vol_data = '0;
    logic [3:0] amp_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    tone_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .freq_we(freq_we), .freq_data(freq_data),
        .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
        .vol_we(vol_we), .vol_data(vol_data),
        .amp_o(amp_o)
    );

    // Reference model state
    logic [4:0] m_pc;
    logic [3:0] m_p4;
    logic [4:0] m_p5;
    logic [8:0] m_p9;
    logic       m_tog;
    int         m_dc;
    logic [4:0] m_freq;
    logic [3:0] m_ctrl;
    logic [3:0] m_vol;

    // {shape[3:0], period[4:0], volume[3:0], ticks[7:0]}
    localparam int NV = 14;
    localparam logic [20:0] VEC [NV] = '{
        {4'b0000, 5'd2,  4'd7,  8'd20},
        {4'b0001, 5'd0,  4'd15, 8'd40},
        {4'b0010, 5'd0,  4'd9,  8'd250},
        {4'b0011, 5'd1,  4'd12, 8'd120},
        {4'b0100, 5'd0,  4'd5,  8'd30},
        {4'b0101, 5'd4,  4'd3,  8'd60},
        {4'b0110, 5'd0,  4'd11, 8'd100},
        {4'b0111, 5'd0,  4'd14, 8'd100},
        {4'b1000, 5'd0,  4'd10, 8'd255},
        {4'b1001, 5'd3,  4'd8,  8'd150},
        {4'b1011, 5'd31, 4'd6,  8'd70},
        {4'b1100, 5'd1,  4'd13, 8'd60},
        {4'b1110, 5'd0,  4'd15, 8'd255},
        {4'b1111, 5'd0,  4'd4,  8'd200}
    };

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000, 4'b1011:                            return "R3";
            4'b0001, 4'b1000, 4'b1001:                   return "R4";
            4'b0100, 4'b0101:                            return "R5";
            4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b1110: return "R6";
            4'b0010:                                     return "R7";
            default:                                     return "R8";
        endcase
    endfunction

    function automatic logic [3:0] p4n(input logic [3:0] s);
        return {s[2:0], s[3] ^ s[2]};
    endfunction
    function automatic logic [4:0] p5n(input logic [4:0] s);
        return {s[3:0], s[4] ^ s[2]};
    endfunction
    function automatic logic [8:0] p9n(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction
    function automatic int wrapinc(input int v, input int n);
        return (v >= n - 1) ? 0 : v + 1;
    endfunction

    task automatic model_reset();
        m_pc = '0; m_p4 = '1; m_p5 = '1; m_p9 = '1; m_tog = 1'b0; m_dc = 0;
        m_freq = '0; m_ctrl = '0; m_vol = '0;
    endtask

    task automatic model_step();
        logic old5;
        old5 = m_p5[4];
        case (m_ctrl)
            4'b0001: m_p4 = p4n(m_p4);
            4'b1000: m_p9 = p9n(m_p9);
            4'b1001: m_p5 = p5n(m_p5);
            4'b0100, 4'b0101: m_tog = ~m_tog;
            4'b0110, 4'b1010: m_dc = wrapinc(m_dc, 31);
            4'b1100, 4'b1101: m_dc = wrapinc(m_dc, 6);
            4'b1110: m_dc = wrapinc(m_dc, 93);
            4'b0010: begin
                if (m_dc >= 14) m_p4 = p4n(m_p4);
                m_dc = wrapinc(m_dc, 15);
            end
            4'b0011: begin m_p5 = p5n(m_p5); if (old5) m_p4 = p4n(m_p4); end
            4'b0111: begin m_p5 = p5n(m_p5); if (old5) m_tog = ~m_tog; end
            4'b1111: begin m_p5 = p5n(m_p5); if (old5) m_dc = wrapinc(m_dc, 6); end
            default: ;
        endcase
    endtask

    task automatic model_tick();
        if (m_pc == 0) begin
            m_pc = m_freq;
            model_step();
        end else begin
            m_pc = m_pc - 5'd1;
        end
    endtask

    function automatic logic [3:0] model_amp();
        logic w;
        case (m_ctrl)
            4'b0000, 4'b1011:          w = 1'b1;
            4'b0001, 4'b0010, 4'b0011: w = m_p4[3];
            4'b1000:                   w = m_p9[8];
            4'b1001:                   w = m_p5[4];
            4'b0100, 4'b0101, 4'b0111: w = m_tog;
            4'b0110, 4'b1010:          w = (m_dc < 16);
            4'b1110:                   w = (m_dc < 47);
            default:                   w = (m_dc < 3);
        endcase
        return w ? m_vol : 4'd0;
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: amp=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic do_tick();
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        model_tick();
    endtask

    task automatic wr_freq(input logic [4:0] v);
        @(negedge clk) begin freq_we = 1'b1; freq_data = v; end
        @(negedge clk) freq_we = 1'b0;
        m_freq = v;
    endtask

    task automatic wr_ctrl(input logic [3:0] v);
        @(negedge clk) begin ctrl_we = 1'b1; ctrl_data = v; end
        @(negedge clk) ctrl_we = 1'b0;
        m_ctrl = v;
    endtask

    task automatic wr_vol(input logic [3:0] v);
        @(negedge clk) begin vol_we = 1'b1; vol_data = v; end
        @(negedge clk) vol_we = 1'b0;
        m_vol = v;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R10: reset state
        do_reset();
        chk("R10", amp_o, 4'd0);

        // R9: silent at volume 0, volume write visible without a step
        chk("R9", amp_o, model_amp());
        wr_vol(4'd9);
        chk("R9", amp_o, 4'd9);

        // Table walk: every shape code with its reference model; R1 for the period
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr_freq(VEC[i][16:12]);
            wr_ctrl(VEC[i][20:17]);
            wr_vol(VEC[i][11:8]);
            chk({tag_of(VEC[i][20:17]), "/R9"}, amp_o, model_amp());
            for (int t = 0; t < int'(VEC[i][7:0]); t++) begin
                do_tick();
                chk({tag_of(VEC[i][20:17]), "/R1"}, amp_o, model_amp());
            end
        end

        // R2: period change mid-count takes effect at next reload
        do_reset();
        wr_ctrl(4'b0100);
        wr_vol(4'd15);
        wr_freq(5'd3);
        chk("R2", amp_o, 4'd0);
        do_tick();
        chk("R2", amp_o, 4'd15);
        wr_freq(5'd0);
        chk("R2", amp_o, 4'd15);
        do_tick(); chk("R2", amp_o, 4'd15);
        do_tick(); chk("R2", amp_o, 4'd15);
        do_tick(); chk("R2", amp_o, 4'd15);
        do_tick(); chk("R2", amp_o, 4'd0);
        do_tick(); chk("R2", amp_o, 4'd15);

        // R4: 5-bit register MSB from all ones is 1,1,1,1,0
        do_reset();
        wr_ctrl(4'b1001);
        wr_vol(4'd7);
        for (int t = 0; t < 4; t++) begin
            do_tick();
            chk("R4", amp_o, 4'd7);
        end
        do_tick();
        chk("R4", amp_o, 4'd0);

        // R11: DIV93 to count 50, then DIV6 wraps the counter to 0
        do_reset();
        wr_ctrl(4'b1110);
        wr_vol(4'd12);
        for (int t = 0; t < 50; t++) do_tick();
        chk("R11", amp_o, 4'd0);
        wr_ctrl(4'b1100);
        chk("R11", amp_o, 4'd0);
        do_tick();
        chk("R11", amp_o, 4'd12);

        // R3: code 1011 holds high after other activity
        wr_ctrl(4'b1011);
        chk("R3", amp_o, 4'd12);
        do_tick();
        chk("R3", amp_o, 4'd12);

        finish_run();
    end

endmodule